// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block turns two low-power request lines into the operating mode of a data converter core. One line asks for a light sleep, where references stay biased and the core is stopped. The other asks for a deep sleep, where everything is off. The deep-sleep line always wins. The core-enable output and the bias-enable output follow the selected mode.

When no request is present, the block does not go straight back to normal operation. It first passes through a recovery phase whose length depends on the sleep level just left. A short recovery follows light sleep and a long one follows deep sleep. The ready flag stays low until that recovery time has elapsed. A new request during recovery cancels the recovery at once. The request lines may come from any clock domain and are synchronized inside the block. Both recovery times are parameters given in clock cycles, for example 100 cycles for 800 ns and 125000 cycles for 1 ms at 125 MHz.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is low, and in the cycles before the first release, the mode output is 2'd2 (deep sleep) with ready, core enable and bias enable all low. Reset behaves as if deep sleep had just been left.
- R2: A change on a request line shows on the mode output after exactly SYNC_STAGES+1 rising clock edges. Until then the previous mode is still shown.
- R3: Mode encoding: 2'd0 is run, 2'd1 is light sleep, 2'd2 is deep sleep and 2'd3 is recovery. The deep-sleep request selects 2'd2 whatever the light-sleep request is. The light-sleep request alone selects 2'd1.
- R4: Outputs per mode. Run gives core 1, bias 1, ready 1. Light sleep gives core 0, bias 1, ready 0. Deep sleep gives core 0, bias 0, ready 0. Recovery gives core 1, bias 1, ready 0.
- R5: After the release of light sleep, the mode is 2'd3 for exactly STBY_WAKE_CYCLES cycles and then becomes 2'd0.
- R6: After the release of deep sleep, the mode is 2'd3 for exactly PDN_WAKE_CYCLES cycles and then becomes 2'd0.
- R7: A request that arrives during recovery enters the requested sleep mode with the latency of R2, and ready stays low.
- R8: A direct move from deep sleep to light sleep makes the next release use the light-sleep recovery time.
- R9: Re-entering deep sleep during a recovery and then releasing it restarts the full deep-sleep recovery time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req_i | input | 1 | Light-sleep request, asynchronous |
| pdn_req_i | input | 1 | Deep-sleep request, asynchronous, has priority |
| mode_o | output | 2 | Current mode (encoding in R3) |
| core_en_o | output | 1 | Converter core enable |
| bias_en_o | output | 1 | Reference and bias enable |
| ready_o | output | 1 | High in run mode once recovery has elapsed |

## Verification
The bench builds the block with SYNC_STAGES=2, STBY_WAKE_CYCLES=5 and PDN_WAKE_CYCLES=12. These short, unequal recovery times let each recovery run to its end within a few dozen cycles. The inequality means a timer loaded with the wrong length lands on a different cycle than the expected one. A deep-sleep recovery of 12 cycles also leaves room to inject a new request in the middle of a countdown, which exercises cancellation and restart. It also shows the first and last recovery cycles at exact offsets from the edge where a request changed.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_RUN  = 2'd0,
    LPM_STBY = 2'd1,
    LPM_PDN  = 2'd2,
    LPM_WAKE = 2'd3
  } lpm_mode_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_STBY = 2'd1,
    REQ_PDN  = 2'd2
  } lpm_req_e;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/lpm_req_decode.sv
module lpm_req_decode
  import lpm_pkg::*;
(
  input  logic     stby,
  input  logic     pdn,
  output lpm_req_e req
);
  always_comb begin
    if (pdn)       req = REQ_PDN;
    else if (stby) req = REQ_STBY;
    else           req = REQ_NONE;
  end
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int STBY_CYCLES = 100,
  parameter int PDN_CYCLES  = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_pdn,
  input  logic run,
  output logic done
);
  localparam int LONGEST = (STBY_CYCLES > PDN_CYCLES) ? STBY_CYCLES : PDN_CYCLES;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] STBY_LOAD = CW'(STBY_CYCLES - 1);
  localparam logic [CW-1:0] PDN_LOAD  = CW'(PDN_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load | (run & ~done);

  always_comb begin
    if (load) cnt_d = load_pdn ? PDN_LOAD : STBY_LOAD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES      = 2,
  parameter int STBY_WAKE_CYCLES = 100,
  parameter int PDN_WAKE_CYCLES  = 125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req_i,
  input  logic       pdn_req_i,
  output logic [1:0] mode_o,
  output logic       core_en_o,
  output logic       bias_en_o,
  output logic       ready_o
);
  logic [1:0] req_s;
  logic       stby_s, pdn_s;
  lpm_req_e   req;
  lpm_mode_e  state_q, state_d;
  logic       t_load, t_load_pdn, t_run, t_done;

  lpm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({pdn_req_i, stby_req_i}),
    .q (req_s)
  );
  assign stby_s = req_s[0];
  assign pdn_s  = req_s[1];

  lpm_req_decode u_dec (
    .stby (stby_s),
    .pdn (pdn_s),
    .req (req)
  );

  lpm_wake_timer #(
    .STBY_CYCLES (STBY_WAKE_CYCLES),
    .PDN_CYCLES (PDN_WAKE_CYCLES)
  ) u_tmr (
    .clk (clk),
    .rst_n (rst_n),
    .load (t_load),
    .load_pdn (t_load_pdn),
    .run (t_run),
    .done (t_done)
  );

  // next-state: a request always wins, release goes through recovery
  always_comb begin
    state_d    = state_q;
    t_load     = 1'b0;
    t_load_pdn = 1'b0;
    t_run      = 1'b0;
    case (req)
      REQ_PDN:  state_d = LPM_PDN;
      REQ_STBY: state_d = LPM_STBY;
      default: begin
        case (state_q)
          LPM_STBY, LPM_PDN: begin
            state_d    = LPM_WAKE;
            t_load     = 1'b1;
            t_load_pdn = (state_q == LPM_PDN);
          end
          LPM_WAKE: begin
            t_run = 1'b1;
            if (t_done) state_d = LPM_RUN;
          end
          default: state_d = LPM_RUN;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LPM_PDN;
    else        state_q <= state_d;
  end

  assign mode_o    = state_q;
  assign ready_o   = (state_q == LPM_RUN);
  assign core_en_o = (state_q == LPM_RUN) || (state_q == LPM_WAKE);
  assign bias_en_o = (state_q != LPM_PDN);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int STBY_WAKE_CYCLES = 100,
  parameter int PDN_WAKE_CYCLES  = 125000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stby_s,
  input logic       pdn_s,
  input logic [1:0] mode_o,
  input logic       core_en_o,
  input logic       bias_en_o,
  input logic       ready_o
);
  int   wake_len;
  logic left_pdn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_len <= 0;
      left_pdn <= 1'b1;
    end else begin
      wake_len <= (mode_o == 2'd3) ? wake_len + 1 : 0;
      if (mode_o == 2'd2)      left_pdn <= 1'b1;
      else if (mode_o == 2'd1) left_pdn <= 1'b0;
    end
  end

  assert_pdn_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_s |=> (mode_o == 2'd2));

  assert_stby_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_s && !pdn_s) |=> (mode_o == 2'd1));

  assert_ready_only_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (mode_o == 2'd0) && core_en_o && bias_en_o);

  assert_pdn_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> !core_en_o && !bias_en_o && !ready_o);

  assert_release_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 2'd1 || mode_o == 2'd2) && !stby_s && !pdn_s) |=> (mode_o == 2'd3));

  assert_wake_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (wake_len == (left_pdn ? PDN_WAKE_CYCLES : STBY_WAKE_CYCLES)));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(
  .STBY_WAKE_CYCLES (STBY_WAKE_CYCLES),
  .PDN_WAKE_CYCLES (PDN_WAKE_CYCLES)
) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .stby_s (stby_s),
  .pdn_s (pdn_s),
  .mode_o (mode_o),
  .core_en_o (core_en_o),
  .bias_en_o (bias_en_o),
  .ready_o (ready_o)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
  localparam int SYNC = 2;
  localparam int NS   = 5;
  localparam int NP   = 12;
  localparam int LAT  = SYNC + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stby = 1'b0;
  logic       pdn = 1'b0;
  logic [1:0] mode;
  logic       core_en, bias_en, ready;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int     q_cyc[$];
  logic [1:0] q_mode[$];
  string  q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpm_ctrl #(
    .SYNC_STAGES (SYNC),
    .STBY_WAKE_CYCLES (NS),
    .PDN_WAKE_CYCLES (NP)
  ) i_lpm_ctrl (
    .clk (clk),
    .rst_n (rst_n),
    .stby_req_i (stby),
    .pdn_req_i (pdn),
    .mode_o (mode),
    .core_en_o (core_en),
    .bias_en_o (bias_en),
    .ready_o (ready)
  );

  // expected outputs per mode, from R4
  function automatic logic [2:0] outs_of(input logic [1:0] m);
    case (m)
      2'd0: return 3'b111;   // core, bias, ready
      2'd1: return 3'b010;
      2'd2: return 3'b000;
      default: return 3'b110;
    endcase
  endfunction

  task automatic compare(input logic [1:0] m, input string tag);
    logic [2:0] exp_o, act_o;
    exp_o = outs_of(m);
    act_o = {core_en, bias_en, ready};
    checks++;
    if (mode !== m || act_o !== exp_o) begin
      errors++;
      $display("FAIL %s cyc=%0d: mode=%0d outs=%b expected mode=%0d outs=%b",
               tag, cyc, mode, act_o, m, exp_o);
    end
  endtask

  task automatic push(input int c, input logic [1:0] m, input string tag);
    q_cyc.push_back(c);
    q_mode.push_back(m);
    q_tag.push_back(tag);
  endtask

  // monitor: pops expectations due at this cycle
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      if (q_cyc[0] < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s: expectation for cyc %0d missed at %0d", q_tag[0], q_cyc[0], cyc);
      end else begin
        compare(q_mode[0], q_tag[0]);
      end
      void'(q_cyc.pop_front());
      void'(q_mode.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic drive(input logic s, input logic p, output int c0);
    @(negedge clk);
    stby = s;
    pdn  = p;
    c0   = cyc;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic enter(input logic s, input logic p, input logic [1:0] prev,
                       input logic [1:0] m, input string tag);
    int c;
    drive(s, p, c);
    push(c + LAT - 1, prev, {tag, " (R2 latency)"});
    push(c + LAT, m, tag);
    wait_to(c + LAT + 2);
  endtask

  task automatic release_to_run(input int n, input string tag);
    int c;
    drive(1'b0, 1'b0, c);
    push(c + LAT, 2'd3, tag);
    push(c + LAT + n - 1, 2'd3, tag);
    push(c + LAT + n, 2'd0, tag);
    wait_to(c + LAT + n + 1);
  endtask

  initial begin
    int c, c2;
    // R1: reset state
    repeat (3) @(negedge clk);
    compare(2'd2, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    c = cyc;
    push(c + 1, 2'd3, "R1 wake after reset");
    push(c + NP, 2'd3, "R6 reset wake");
    push(c + NP + 1, 2'd0, "R6 reset wake end");
    wait_to(c + NP + 2);

    // R3/R5: light sleep and release
    enter(1'b1, 1'b0, 2'd0, 2'd1, "R3 stby");
    release_to_run(NS, "R5 stby release");

    // R3 priority, then R8 deep->light direct
    enter(1'b1, 1'b1, 2'd0, 2'd2, "R3 pdn priority");
    enter(1'b1, 1'b0, 2'd2, 2'd1, "R8 pdn to stby");
    release_to_run(NS, "R8 stby time used");

    // R7: cancel deep-sleep recovery with light-sleep request
    enter(1'b0, 1'b1, 2'd0, 2'd2, "R3 pdn");
    drive(1'b0, 1'b0, c);
    push(c + LAT, 2'd3, "R6 wake start");
    wait_to(c + LAT + 2);
    drive(1'b1, 1'b0, c2);
    push(c2 + LAT - 1, 2'd3, "R7 still waking");
    push(c2 + LAT, 2'd1, "R7 cancel to stby");
    wait_to(c2 + LAT + 2);
    release_to_run(NS, "R7 stby release");

    // R9: re-enter deep sleep mid-recovery, full recovery again
    enter(1'b0, 1'b1, 2'd0, 2'd2, "R3 pdn");
    drive(1'b0, 1'b0, c);
    push(c + LAT, 2'd3, "R6 wake start");
    wait_to(c + LAT + 5);
    drive(1'b0, 1'b1, c2);
    push(c2 + LAT - 1, 2'd3, "R9 still waking");
    push(c2 + LAT, 2'd2, "R9 reenter pdn");
    wait_to(c2 + LAT + 2);
    release_to_run(NP, "R9 full pdn time");

    wait_to(cyc + 2);
    if (q_cyc.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", q_cyc.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, cyc=%0d expected < 5000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule